// File: doc/BRIEF.md
# Programmable Block Transfer Controller

This block is a device-side controller that moves a block of data between a byte-wide device stream and a word-wide system memory port, with no processor loads or stores during the move. Software sets up a sector number, a memory base address, a byte count and a direction through a small register bus. It then writes a start register. The controller tells the device which sector to serve and streams the data through an internal word buffer. The buffer keeps data flowing while the memory port holds off requests.

The device side produces or consumes data at its own fixed pace and cannot be paused. On the memory side, the port uses a valid/ready handshake, and reads return one word on a separate response strobe. Progress is reported in a status word. An interrupt line rises when a transfer finishes or fails, and it falls when software reads the status word. Each transfer works from a private copy of the settings, taken at start, so software may reprogram the registers for the next job while a transfer is running.

Top module: `dmamv_top`

## Requirements
- R1: After reset the status word reads 0, the interrupt is low and no memory request is presented.
- R2: Register word offsets: 0x00 sector, 0x04 memory base address, 0x08 byte count, 0x0C control (bit 0 direction, 1 = device to memory, 0 = memory to device), 0x10 start, 0x14 status (bit 0 busy, bit 1 done, bit 2 overrun, bit 3 bad length). A read strobe returns the addressed value on `reg_rdata` one cycle later.
- R3: A start write with a valid count sets busy, shows the programmed sector on `dev_sector` and pulses `dev_start` for exactly one cycle.
- R4: In the device-to-memory direction, every 4 received bytes form one word with the first byte in bits 7:0. Words are written to ascending word addresses from the base. When the last write is accepted, done is set and busy is cleared.
- R5: A memory request held off by `mem_ready` keeps its address, data and write flag unchanged. Up to 16 words are buffered, so stalls lose no data.
- R6: If a received byte completes a word while the buffer is full, the overrun bit is set and the transfer ends at once with busy and done both clear. No further memory writes follow.
- R7: A start write with a count of zero, or a count that is not a multiple of 4, sets the bad-length bit at once. It does not set busy and causes no memory or device activity.
- R8: In the memory-to-device direction, words are read from ascending addresses and sent out byte by byte, bits 7:0 first. Done is set after the last byte is taken.
- R9: Register writes made while busy do not affect the running transfer. A start write while busy is ignored.
- R10: Device bytes beyond the programmed count are ignored and cause no memory write.
- R11: The interrupt rises when done, overrun or bad length is set. It falls after a read of the status offset. The next accepted start clears done and both error bits.
- R12: At most one memory read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Completion or error interrupt |
| dev_start | output | 1 | One-cycle pulse: the device starts serving a sector |
| dev_sector | output | 32 | Sector number of the running transfer |
| dev_dir | output | 1 | Direction of the running transfer |
| dev_rx_valid | input | 1 | Device byte present |
| dev_rx_data | input | 8 | Device byte |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte to the device |
| dev_tx_ready | input | 1 | Device takes the offered byte |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response data |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. A stalled memory request must stay stable, and only one read may be outstanding. Done and bad length must never appear while busy. An overrun must end the transfer in the same cycle it is flagged, and every interrupt rise must have a status cause. Other behaviour can only be shown by the bench's scenarios, because it needs a reference model of memory contents and byte order. This includes little-endian packing and unpacking and ascending addressing. It also includes exact buffer depth before overrun, ignored bytes beyond the count, and settings held across a reprogramming mid-transfer.

// File: rtl/dmamv_pkg.sv
package dmamv_pkg;
  localparam logic [4:0] OFS_SECTOR = 5'h00;
  localparam logic [4:0] OFS_ADDR   = 5'h04;
  localparam logic [4:0] OFS_LEN    = 5'h08;
  localparam logic [4:0] OFS_CTRL   = 5'h0C;
  localparam logic [4:0] OFS_GO     = 5'h10;
  localparam logic [4:0] OFS_STAT   = 5'h14;

  // packed so that busy lands in bit 0, bad length in bit 3
  typedef struct packed {
    logic lerr;
    logic ovr;
    logic done;
    logic busy;
  } stat_t;
endpackage

// File: rtl/dmamv_fifo.sv
module dmamv_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign rdata = store[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/dmamv_regs.sv
module dmamv_regs
  import dmamv_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  input  logic               busy,
  input  logic               fin_ok,
  input  logic               fin_ovr,
  output logic               start,
  output logic [31:0]        cfg_sector,
  output logic [AW-1:0]      cfg_addr,
  output logic [LEN_W-3:0]   cfg_words,
  output logic               cfg_dir,
  output stat_t              status
);
  logic [LEN_W-1:0] len_q;
  logic done_q, ovr_q, lerr_q;
  logic go_hit, len_bad;

  assign go_hit  = reg_wr && (reg_addr == OFS_GO) && !busy;
  assign len_bad = (len_q == '0) || (len_q[1:0] != 2'b00);
  assign start   = go_hit && !len_bad;
  assign cfg_words = len_q[LEN_W-1:2];
  assign status  = '{lerr: lerr_q, ovr: ovr_q, done: done_q, busy: busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_sector <= '0;
      cfg_addr   <= '0;
      len_q      <= '0;
      cfg_dir    <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_SECTOR: cfg_sector <= reg_wdata;
        OFS_ADDR:   cfg_addr   <= reg_wdata[AW-1:0];
        OFS_LEN:    len_q      <= reg_wdata[LEN_W-1:0];
        OFS_CTRL:   cfg_dir    <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      lerr_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (go_hit) begin
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
        lerr_q <= len_bad;
      end
      if (fin_ok)  done_q <= 1'b1;
      if (fin_ovr) ovr_q  <= 1'b1;
      if ((go_hit && len_bad) || fin_ok || fin_ovr) irq <= 1'b1;
      else if (reg_rd && reg_addr == OFS_STAT)      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_SECTOR: reg_rdata <= cfg_sector;
        OFS_ADDR:   reg_rdata <= 32'(cfg_addr);
        OFS_LEN:    reg_rdata <= 32'(len_q);
        OFS_CTRL:   reg_rdata <= {31'd0, cfg_dir};
        OFS_STAT:   reg_rdata <= {28'd0, status};
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmamv_engine.sv
module dmamv_engine #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      cfg_sector,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [LEN_W-3:0] cfg_words,
  input  logic             cfg_dir,
  output logic             run,
  output logic             fin_ok,
  output logic             fin_ovr,
  output logic             dev_start,
  output logic [31:0]      dev_sector,
  output logic             dev_dir,
  input  logic             dev_rx_valid,
  input  logic [7:0]       dev_rx_data,
  output logic             dev_tx_valid,
  output logic [7:0]       dev_tx_data,
  input  logic             dev_tx_ready,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             f_clr,
  output logic             f_push,
  output logic [31:0]      f_wdata,
  output logic             f_pop,
  input  logic [31:0]      f_rdata,
  input  logic             f_full,
  input  logic             f_empty
);
  localparam int WC = LEN_W - 2;

  logic [AW-1:0] base_q;
  logic [WC-1:0] words_q, in_cnt, out_cnt;
  logic [1:0]    pk_idx, tx_idx;
  logic [23:0]   pk_sh;
  logic          pend;
  logic rx_take, word_done, mem_fire, tx_fire, rd_issue;

  assign rx_take   = run && dev_dir && dev_rx_valid && (in_cnt < words_q);
  assign word_done = rx_take && (pk_idx == 2'd3);
  assign fin_ovr   = word_done && f_full;

  assign mem_we    = dev_dir;
  assign mem_valid = dev_dir ? (run && !f_empty)
                             : (run && !pend && !f_full && (in_cnt < words_q));
  assign mem_addr  = base_q + AW'({(dev_dir ? out_cnt : in_cnt), 2'b00});
  assign mem_wdata = f_rdata;
  assign mem_fire  = mem_valid && mem_ready;
  assign rd_issue  = mem_fire && !dev_dir;

  assign dev_tx_valid = run && !dev_dir && !f_empty;
  assign dev_tx_data  = f_rdata[{tx_idx, 3'b000} +: 8];
  assign tx_fire      = dev_tx_valid && dev_tx_ready;

  assign f_clr   = start;
  assign f_push  = (word_done && !f_full) || (run && !dev_dir && pend && mem_rvalid);
  assign f_wdata = dev_dir ? {dev_rx_data, pk_sh} : mem_rdata;
  assign f_pop   = dev_dir ? mem_fire : (tx_fire && tx_idx == 2'd3);
  assign fin_ok  = f_pop && ((out_cnt + WC'(1)) == words_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      dev_start  <= 1'b0;
      dev_sector <= '0;
      dev_dir    <= 1'b0;
      base_q     <= '0;
      words_q    <= '0;
      in_cnt     <= '0;
      out_cnt    <= '0;
      pk_idx     <= '0;
      pk_sh      <= '0;
      tx_idx     <= '0;
      pend       <= 1'b0;
    end else if (start) begin
      run        <= 1'b1;
      dev_start  <= 1'b1;
      dev_sector <= cfg_sector;
      dev_dir    <= cfg_dir;
      base_q     <= cfg_addr;
      words_q    <= cfg_words;
      in_cnt     <= '0;
      out_cnt    <= '0;
      pk_idx     <= '0;
      tx_idx     <= '0;
      pend       <= 1'b0;
    end else begin
      dev_start <= 1'b0;
      if (fin_ok || fin_ovr) run <= 1'b0;
      if (rx_take) begin
        pk_idx <= pk_idx + 2'd1;
        pk_sh  <= {dev_rx_data, pk_sh[23:8]};
      end
      if (word_done || rd_issue) in_cnt <= in_cnt + WC'(1);
      if (f_pop) out_cnt <= out_cnt + WC'(1);
      if (tx_fire) tx_idx <= tx_idx + 2'd1;
      if (rd_issue) pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dmamv_top.sv
module dmamv_top
  import dmamv_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          dev_start,
  output logic [31:0]   dev_sector,
  output logic          dev_dir,
  input  logic          dev_rx_valid,
  input  logic [7:0]    dev_rx_data,
  output logic          dev_tx_valid,
  output logic [7:0]    dev_tx_data,
  input  logic          dev_tx_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  logic             busy_w, fin_ok_w, fin_ovr_w, start_w, dir_w;
  logic [31:0]      sector_w;
  logic [AW-1:0]    addr_w;
  logic [LEN_W-3:0] words_w;
  stat_t            stat_w;
  logic             f_clr, f_push, f_pop, f_full, f_empty;
  logic [31:0]      f_wdata, f_rdata;

  dmamv_regs #(.AW(AW), .LEN_W(LEN_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .busy(busy_w), .fin_ok(fin_ok_w), .fin_ovr(fin_ovr_w),
    .start(start_w), .cfg_sector(sector_w), .cfg_addr(addr_w),
    .cfg_words(words_w), .cfg_dir(dir_w), .status(stat_w)
  );

  dmamv_engine #(.AW(AW), .LEN_W(LEN_W)) eng_i (
    .clk(clk), .rst(rst), .start(start_w), .cfg_sector(sector_w),
    .cfg_addr(addr_w), .cfg_words(words_w), .cfg_dir(dir_w),
    .run(busy_w), .fin_ok(fin_ok_w), .fin_ovr(fin_ovr_w),
    .dev_start(dev_start), .dev_sector(dev_sector), .dev_dir(dev_dir),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
    .dev_tx_ready(dev_tx_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .f_clr(f_clr),
    .f_push(f_push), .f_wdata(f_wdata), .f_pop(f_pop), .f_rdata(f_rdata),
    .f_full(f_full), .f_empty(f_empty)
  );

  dmamv_fifo #(.W(32), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .clr(f_clr), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .rdata(f_rdata), .full(f_full), .empty(f_empty)
  );
endmodule

// File: rtl/dmamv_chk.sv
module dmamv_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_we,
  input logic          mem_ready,
  input logic          mem_rvalid,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          irq,
  input logic          busy,
  input logic [3:0]    stat,
  input logic          fin_ovr
);
  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (rst) outst <= '0;
    else outst <= outst + 2'(mem_valid && mem_ready && !mem_we) - 2'(mem_rvalid && outst != 0);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !mem_valid));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready && !fin_ovr) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  assert_one_read_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_we) |-> (outst == 2'd0));

  assert_ovr_ends_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[2]) |-> !busy);

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (stat[3] || stat[2] || stat[1]));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    stat[1] |-> !busy);

  assert_lerr_idle_R7: assert property (@(posedge clk) disable iff (rst)
    stat[3] |-> (!busy && !mem_valid));
endmodule

bind dmamv_top dmamv_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .irq(irq), .busy(busy_w), .stat(stat_w),
  .fin_ovr(fin_ovr_w)
);

// File: tb/dmamv_top_tb_top.sv
`timescale 1ns/1ps
module dmamv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dev_start, dev_dir;
  logic [31:0] dev_sector;
  logic        dev_rx_valid = 1'b0;
  logic [7:0]  dev_rx_data = '0;
  logic        dev_tx_valid;
  logic [7:0]  dev_tx_data;
  logic        dev_tx_ready = 1'b1;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  int wr_count = 0, cyc = 0, stall_mode = 0, ncap = 0;
  bit finished = 0;
  logic [31:0] bmem [64];
  logic [7:0]  cap [64];

  always #2.5 clk = ~clk;

  dmamv_top dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dev_start(dev_start), .dev_sector(dev_sector),
    .dev_dir(dev_dir), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
    .dev_tx_ready(dev_tx_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // stall pattern changes on the falling edge only
  always @(negedge clk) cyc <= cyc + 1;
  assign mem_ready = (stall_mode == 0) ? 1'b1 :
                     (stall_mode == 1) ? (cyc % 4 == 0) : 1'b0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        bmem[mem_addr[7:2]] <= mem_wdata;
        wr_count = wr_count + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= bmem[mem_addr[7:2]];
      end
    end
    if (dev_tx_valid && dev_tx_ready) begin
      cap[ncap] = dev_tx_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_bytes(input int n, input int first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dev_rx_valid = 1'b1;
      dev_rx_data  = 8'(first + i);
    end
    @(negedge clk);
    dev_rx_valid = 1'b0;
  endtask

  task automatic wait_irq();
    for (int n = 0; n < 3000 && !irq; n++) @(negedge clk);
  endtask

  function automatic logic [31:0] packed_word(input int first, input int k);
    return {8'(first + 4*k + 3), 8'(first + 4*k + 2), 8'(first + 4*k + 1), 8'(first + 4*k)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    rd_reg(5'h14, d);
    chk(d == 0, "R1 status", d, 0);
    wr_reg(5'h00, 32'hCAFE_0123);
    rd_reg(5'h00, d);
    chk(d == 32'hCAFE_0123, "R2 sector readback", d, 32'hCAFE_0123);
  endtask

  task automatic t_dev2mem();
    logic [31:0] d;
    stall_mode = 0; wr_count = 0;
    bmem[4] = 32'h5555_5555;
    wr_reg(5'h00, 32'h0000_0777);
    wr_reg(5'h04, 32'h0000_0000);
    wr_reg(5'h08, 32'd16);
    wr_reg(5'h0C, 32'd1);
    wr_reg(5'h10, 32'd1);
    chk(dev_start == 1'b1, "R3 start pulse", 32'(dev_start), 1);
    chk(dev_sector == 32'h777, "R3 sector out", dev_sector, 32'h777);
    rd_reg(5'h14, d);
    chk(d[0] == 1'b1, "R3 busy", d, 1);
    chk(dev_start == 1'b0, "R3 pulse one cycle", 32'(dev_start), 0);
    send_bytes(20, 8'h10);   // 4 extra bytes beyond the count
    wait_irq();
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R11 irq on done", 32'(irq), 1);
    for (int k = 0; k < 4; k++)
      chk(bmem[k] == packed_word(8'h10, k), "R4 packed word", bmem[k], packed_word(8'h10, k));
    chk(wr_count == 4, "R10 write count", 32'(wr_count), 4);
    chk(bmem[4] == 32'h5555_5555, "R10 no extra write", bmem[4], 32'h5555_5555);
    rd_reg(5'h14, d);
    chk(d == 32'h2, "R4 status done", d, 32'h2);
    chk(irq == 1'b0, "R11 irq cleared by status read", 32'(irq), 0);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    stall_mode = 1; wr_count = 0;
    wr_reg(5'h04, 32'h0000_0040);
    wr_reg(5'h08, 32'd32);
    wr_reg(5'h0C, 32'd1);
    wr_reg(5'h10, 32'd1);
    send_bytes(32, 8'h80);
    wait_irq();
    for (int k = 0; k < 8; k++)
      chk(bmem[16 + k] == packed_word(8'h80, k), "R5 stalled data", bmem[16 + k], packed_word(8'h80, k));
    rd_reg(5'h14, d);
    chk(d == 32'h2, "R5 status done", d, 32'h2);
    stall_mode = 0;
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    stall_mode = 2; wr_count = 0;
    wr_reg(5'h04, 32'h0000_0000);
    wr_reg(5'h08, 32'd128);
    wr_reg(5'h0C, 32'd1);
    wr_reg(5'h10, 32'd1);
    send_bytes(80, 8'h01);
    chk(irq == 1'b1, "R6 irq on overrun", 32'(irq), 1);
    rd_reg(5'h14, d);
    chk(d == 32'h4, "R6 overrun status", d, 32'h4);
    stall_mode = 0;
    repeat (10) @(negedge clk);
    chk(wr_count == 0, "R6 no writes after overrun", 32'(wr_count), 0);
  endtask

  task automatic t_lenerr();
    logic [31:0] d;
    wr_count = 0;
    wr_reg(5'h08, 32'd6);
    wr_reg(5'h10, 32'd1);
    chk(irq == 1'b1, "R7 irq on bad length", 32'(irq), 1);
    rd_reg(5'h14, d);
    chk(d == 32'h8, "R7 status odd length", d, 32'h8);
    wr_reg(5'h08, 32'd0);
    wr_reg(5'h10, 32'd1);
    rd_reg(5'h14, d);
    chk(d == 32'h8, "R7 status zero length", d, 32'h8);
    chk(mem_valid == 1'b0 && wr_count == 0, "R7 no activity", 32'(wr_count), 0);
  endtask

  task automatic t_mem2dev();
    logic [31:0] d;
    logic [7:0] e;
    bmem[8] = 32'h4433_2211; bmem[9] = 32'h8877_6655; bmem[10] = 32'hCCBB_AA99;
    ncap = 0; stall_mode = 1;
    wr_reg(5'h04, 32'h0000_0020);
    wr_reg(5'h08, 32'd12);
    wr_reg(5'h0C, 32'd0);
    wr_reg(5'h10, 32'd1);
    chk(dev_dir == 1'b0, "R8 direction out", 32'(dev_dir), 0);
    wait_irq();
    chk(ncap == 12, "R8 byte count", 32'(ncap), 12);
    for (int j = 0; j < 12; j++) begin
      e = bmem[8 + j/4][8*(j%4) +: 8];
      chk(cap[j] == e, "R8 byte order", 32'(cap[j]), 32'(e));
    end
    rd_reg(5'h14, d);
    chk(d == 32'h2, "R8 status done", d, 32'h2);
    stall_mode = 0;
  endtask

  task automatic t_hold_cfg();
    logic [31:0] d;
    stall_mode = 2; wr_count = 0;
    bmem[32] = 32'h1234_5678;
    wr_reg(5'h04, 32'h0000_0060);
    wr_reg(5'h08, 32'd8);
    wr_reg(5'h0C, 32'd1);
    wr_reg(5'h10, 32'd1);
    send_bytes(8, 8'hA0);
    wr_reg(5'h04, 32'h0000_0080);   // reprogram mid-transfer
    wr_reg(5'h08, 32'd4);
    wr_reg(5'h0C, 32'd0);
    wr_reg(5'h10, 32'd1);           // start while busy
    stall_mode = 0;
    wait_irq();
    repeat (4) @(negedge clk);
    chk(bmem[24] == packed_word(8'hA0, 0), "R9 base held", bmem[24], packed_word(8'hA0, 0));
    chk(bmem[25] == packed_word(8'hA0, 1), "R9 count held", bmem[25], packed_word(8'hA0, 1));
    chk(bmem[32] == 32'h1234_5678, "R9 new base unused", bmem[32], 32'h1234_5678);
    chk(wr_count == 2, "R9 second start ignored", 32'(wr_count), 2);
    rd_reg(5'h14, d);
    chk(d == 32'h2, "R9 status done", d, 32'h2);
    rd_reg(5'h04, d);
    chk(d == 32'h80, "R2 address readback", d, 32'h80);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dev2mem();
    t_stall();
    t_overrun();
    t_lenerr();
    t_mem2dev();
    t_hold_cfg();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule